// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a virtual address from a processor into a physical address by walking a single-level page table held in memory. The virtual page number, scaled by the four-byte entry size, is added to a per-process table base value to form the entry address. The entry is fetched over a memory read port that allows one read in flight. The translator checks the entry's presence bit and its read and write rights against the kind of access, and returns either a physical address or a fault status. A missing page and a denied access are reported as different faults.

The processor side uses a valid/ready request carrying the address and a load/store flag. The response is held until the processor acknowledges it. Software changes the table base, for example on a process switch, through a write strobe. That write is honoured only while no translation is in progress.

Top module: `pt_xlate`

## Requirements
- R1: On a successful translation, physical address bits 11:0 equal virtual address bits 11:0 (pages are 4096 bytes).
- R2: The entry read address is the base value plus four times the virtual page number (virtual address bits 31:12), taken modulo 2^32. The read request and its address stay asserted and unchanged until the memory accepts them.
- R3: An entry with bit 0 (present) set and the needed right set yields status 2'b00, with physical address bits 23:12 taken from entry bits 23:12. Entry bits 31:24 and bits 11:3 have no effect.
- R4: An entry with bit 0 clear yields status 2'b01 (page fault) with physical address 0, whatever its right bits hold.
- R5: A present entry yields status 2'b10 (protection fault) with physical address 0 when a load finds entry bit 1 (read) clear or a store finds entry bit 2 (write) clear. The status code 2'b11 is never produced.
- R6: A base write is applied only while the block is idle. A base write made while a translation is in progress is ignored.
- R7: A new request is accepted only when the block is idle, and at most one memory read is outstanding.
- R8: The response valid, address and status stay unchanged until the processor acknowledges the response. After the acknowledge the block is idle again.
- R9: After reset the block is idle, with no response and no memory request pending, and the table base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | 32 | New table base value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Processor acknowledges the result |
| rsp_paddr | output | 24 | Physical address (0 on a fault) |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the page table entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Page table entry contents |

## Verification
The assertions check the following on every cycle: the memory request holding steady while it waits, the held response, request acceptance only while no response is pending, a single outstanding read, the offset passing through unchanged, a zeroed address on faults, and the absence of status 2'b11. Only the bench scenarios can show the right entry address for a given base and page number, the mapping of entry bits to the page number, the choice between page fault and protection fault (including the priority of the page fault), and a base write being ignored during a walk. Those depend on the values that the bench's memory model returns.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 24;
    localparam int PG_BITS   = 12;
    localparam int PTE_W     = 32;
    localparam int PTE_SHIFT = 2;
    localparam int VPN_W     = VA_W - PG_BITS;
    localparam int PPN_W     = PA_W - PG_BITS;
    localparam int PAD_W     = VA_W - VPN_W - PTE_SHIFT;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_READ    = 1;
    localparam int BIT_WRITE   = 2;

    typedef enum logic [1:0] {
        ST_OK         = 2'b00,
        ST_PAGE_FAULT = 2'b01,
        ST_PROT_FAULT = 2'b10
    } xl_status_e;

    typedef enum logic [1:0] {
        S_IDLE, S_READ_PTE, S_WAIT_PTE, S_RESPOND
    } xl_state_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             can_wr;
        logic             can_rd;
        logic             present;
    } pte_t;

    typedef struct packed {
        logic [PA_W-1:0] paddr;
        xl_status_e      status;
    } xl_result_t;

    function automatic pte_t pte_decode(input logic [PTE_W-1:0] raw);
        pte_t e;
        e.ppn     = raw[PA_W-1:PG_BITS];
        e.can_wr  = raw[BIT_WRITE];
        e.can_rd  = raw[BIT_READ];
        e.present = raw[BIT_PRESENT];
        return e;
    endfunction
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg
    import pt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            allow,
    input  logic [VA_W-1:0] wdata,
    output logic [VA_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst)
            base <= '0;
        else if (we && allow)
            base <= wdata;
    end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
    import pt_pkg::*;
(
    input  logic [VA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [VA_W-1:0]  pte_addr
);
    logic [VA_W-1:0] scaled;
    assign scaled   = {{PAD_W{1'b0}}, vpn, {PTE_SHIFT{1'b0}}};
    assign pte_addr = base + scaled;
endmodule

// File: rtl/pt_check.sv
module pt_check
    import pt_pkg::*;
(
    input  logic [PTE_W-1:0]   pte_raw,
    input  logic               is_store,
    input  logic [PG_BITS-1:0] offset,
    output xl_result_t         result
);
    pte_t e;
    logic allowed;

    always_comb begin
        e       = pte_decode(pte_raw);
        allowed = is_store ? e.can_wr : e.can_rd;
        if (!e.present) begin
            result.status = ST_PAGE_FAULT;
            result.paddr  = '0;
        end else if (!allowed) begin
            result.status = ST_PROT_FAULT;
            result.paddr  = '0;
        end else begin
            result.status = ST_OK;
            result.paddr  = {e.ppn, offset};
        end
    end
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
    import pt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             base_we,
    input  logic [VA_W-1:0]  base_wdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_store,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_status,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    xl_state_e          state;
    logic [VPN_W-1:0]   vpn_q;
    logic [PG_BITS-1:0] off_q;
    logic               store_q;
    xl_result_t         result_q;
    xl_result_t         check_out;
    logic [VA_W-1:0]    base;
    logic               idle;

    assign idle = (state == S_IDLE);

    pt_base_reg u_base (
        .clk   (clk),
        .rst   (rst),
        .we    (base_we),
        .allow (idle),
        .wdata (base_wdata),
        .base  (base)
    );

    pt_addr_gen u_addr (
        .base     (base),
        .vpn      (vpn_q),
        .pte_addr (mem_req_addr)
    );

    pt_check u_check (
        .pte_raw  (mem_rsp_data),
        .is_store (store_q),
        .offset   (off_q),
        .result   (check_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            vpn_q    <= '0;
            off_q    <= '0;
            store_q  <= 1'b0;
            result_q <= '{paddr: '0, status: ST_OK};
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    vpn_q   <= req_vaddr[VA_W-1:PG_BITS];
                    off_q   <= req_vaddr[PG_BITS-1:0];
                    store_q <= req_store;
                    state   <= S_READ_PTE;
                end
                S_READ_PTE: if (mem_req_ready) state <= S_WAIT_PTE;
                S_WAIT_PTE: if (mem_rsp_valid) begin
                    result_q <= check_out;
                    state    <= S_RESPOND;
                end
                S_RESPOND: if (rsp_ready) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready     = idle;
    assign mem_req_valid = (state == S_READ_PTE);
    assign rsp_valid     = (state == S_RESPOND);
    assign rsp_paddr     = result_q.paddr;
    assign rsp_status    = result_q.status;
endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk
    import pt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_status,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [VA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid
);
    logic [PG_BITS-1:0] seen_off;
    logic               rd_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_off   <= '0;
            rd_pending <= 1'b0;
        end else begin
            if (req_valid && req_ready) seen_off <= req_vaddr[PG_BITS-1:0];
            if (mem_req_valid && mem_req_ready) rd_pending <= 1'b1;
            else if (mem_rsp_valid) rd_pending <= 1'b0;
        end
    end

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'b00) |-> (rsp_paddr[PG_BITS-1:0] == seen_off));

    assert_memreq_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'b00) |-> (rsp_paddr == '0));

    assert_no_code3_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'b11));

    assert_single_read_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !rd_pending);

    assert_accept_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && (rsp_valid || mem_req_valid)));

    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)));
endmodule

bind pt_xlate pt_xlate_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_status    (rsp_status),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/pt_xlate_tb_top.sv
module pt_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [23:0] rsp_paddr;
    logic [1:0]  rsp_status;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pt_xlate dut_i (.*);

    typedef struct packed {
        logic [31:0] vaddr;
        logic        store;
        logic [31:0] pte;
        logic [3:0]  lat;
        logic [3:0]  dly;
        logic [1:0]  exp_st;
        logic [23:0] exp_pa;
        logic [31:0] exp_addr;
    } vec_t;

    // base is 32'h0001_0000 for every vector
    localparam vec_t VECS [0:7] = '{
        '{32'h0000_3ABC, 1'b0, 32'h005A_5003, 4'd0, 4'd0, 2'b00, 24'h5A5ABC, 32'h0001_000C}, // R3 load ok
        '{32'h0012_3FFF, 1'b1, 32'h00FF_F007, 4'd2, 4'd1, 2'b00, 24'hFFFFFF, 32'h0001_048C}, // R3 store ok
        '{32'h0000_1000, 1'b0, 32'h00AB_C006, 4'd1, 4'd0, 2'b01, 24'h000000, 32'h0001_0004}, // R4 not present
        '{32'hFFFF_F000, 1'b1, 32'h0012_3003, 4'd0, 4'd2, 2'b10, 24'h000000, 32'h0040_FFFC}, // R5 store no write
        '{32'h0000_0FFF, 1'b0, 32'h0045_6005, 4'd3, 4'd0, 2'b10, 24'h000000, 32'h0001_0000}, // R5 load no read
        '{32'h0004_2123, 1'b0, 32'h0000_0000, 4'd0, 4'd0, 2'b01, 24'h000000, 32'h0001_0108}, // R4 priority
        '{32'h0000_5555, 1'b1, 32'h0077_7005, 4'd1, 4'd3, 2'b00, 24'h777555, 32'h0001_0014}, // R3 store w/o read
        '{32'h0000_9000, 1'b0, 32'hFFAB_CFFB, 4'd0, 4'd1, 2'b00, 24'hABC000, 32'h0001_0024}  // R3 ignored bits
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk); base_we = 1'b1; base_wdata = v;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic xlate(input vec_t v, input bit busy_write, input logic [31:0] busy_val);
        @(negedge clk);
        check(req_ready == 1'b1, "R7", "ready when idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = v.vaddr; req_store = v.store;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R7", "not ready when busy", {31'b0, req_ready}, 32'd0);
        for (int i = 0; i < int'(v.lat); i++) begin
            check(mem_req_valid == 1'b1, "R2", "read held", {31'b0, mem_req_valid}, 32'd1);
            @(negedge clk);
        end
        check(mem_req_valid == 1'b1, "R2", "read valid", {31'b0, mem_req_valid}, 32'd1);
        check(mem_req_addr == v.exp_addr, "R2", "entry address", mem_req_addr, v.exp_addr);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid == 1'b0, "R7", "one read only", {31'b0, mem_req_valid}, 32'd0);
        if (busy_write) begin
            base_we = 1'b1; base_wdata = busy_val;
            @(negedge clk);
            base_we = 1'b0;
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = v.pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
        for (int i = 0; i <= int'(v.dly); i++) begin
            check(rsp_valid == 1'b1, "R8", "response held", {31'b0, rsp_valid}, 32'd1);
            check(rsp_status == v.exp_st, v.exp_st == 2'b00 ? "R3" : (v.exp_st == 2'b01 ? "R4" : "R5"),
                  "status", {30'b0, rsp_status}, {30'b0, v.exp_st});
            check(rsp_paddr == v.exp_pa, v.exp_st == 2'b00 ? "R1" : "R4", "paddr",
                  {8'b0, rsp_paddr}, {8'b0, v.exp_pa});
            if (i == int'(v.dly)) rsp_ready = 1'b1;
            @(negedge clk);
        end
        rsp_ready = 1'b0;
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R8", "idle after ack",
              {30'b0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        vec_t t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check(req_ready == 1'b1, "R9", "ready", {31'b0, req_ready}, 32'd1);
        check(rsp_valid == 1'b0, "R9", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check(mem_req_valid == 1'b0, "R9", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        // R9 base 0: page 5 entry at 0x14
        t = '{32'h0000_5010, 1'b0, 32'h0001_2003, 4'd0, 4'd0, 2'b00, 24'h012010, 32'h0000_0014};
        xlate(t, 1'b0, '0);

        write_base(32'h0001_0000);
        for (int k = 0; k < 8; k++) xlate(VECS[k], 1'b0, '0);

        // R2 address wraps modulo 2^32
        write_base(32'hFFFF_FFF0);
        t = '{32'h0000_8123, 1'b1, 32'h0034_5007, 4'd0, 4'd0, 2'b00, 24'h345123, 32'h0000_0010};
        xlate(t, 1'b0, '0);

        // R6 write during walk ignored
        write_base(32'h0002_0000);
        t = '{32'h0000_2000, 1'b0, 32'h0011_1003, 4'd1, 4'd0, 2'b00, 24'h111000, 32'h0002_0008};
        xlate(t, 1'b1, 32'h0003_0000);
        t = '{32'h0000_1ABC, 1'b0, 32'h0022_2003, 4'd0, 4'd0, 2'b00, 24'h222ABC, 32'h0002_0004};
        xlate(t, 1'b0, '0);

        // R7 request held while response pending is not taken twice
        t = '{32'h0000_3001, 1'b1, 32'h0000_0001, 4'd0, 4'd0, 2'b10, 24'h000000, 32'h0002_000C};
        xlate(t, 1'b0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule